// File: doc/BRIEF.md
# DMA Channel Register File

This block is the processor side of a four-channel direct memory access controller. A host reaches it through an 8-bit port with chip select, read strobe, write strobe and a 4-bit register address. Every channel owns a 16-bit start address and a 16-bit transfer count. Each of these exists twice: a base copy written by software and a working copy that the transfer engine steps. One shared byte pointer decides whether an 8-bit access reaches the low or the high half of a 16-bit register. Software programs a register in two accesses, low byte first.

The block also stores a command byte, a mode byte for each channel, a software request per channel, a temporary byte and per-channel terminal-count flags. The transfer sequencer and the bus arbiter sit outside this block. They read the register contents from output buses, see a one-cycle load pulse after software reprograms a channel, and drive step, terminal-count, request and temporary-data inputs back in. A software master-clear returns the control state to idle and leaves the channel addresses, counts and modes as they are.

The host port is a plain strobe interface and not a stream. It completes one access in every clock in which `cs` is high with `rd` or `wr`. It never stalls, so it has no back-pressure. Read data is combinational in the access cycle, and every side effect of an access takes place at the clock edge that ends that cycle.

Top module: `dma_regfile`

## Requirements
- R1: After reset every register, every output bus, the byte pointer and `rdata` are zero.
- R2: A write to address 2n (start address) or 2n+1 (count) of channel n stores `wdata` in the low byte when the byte pointer is 0 and in the high byte when it is 1. The other byte is kept. The working copy takes the whole new base value at the same edge.
- R3: The byte pointer inverts after every read or write at addresses 0 to 7, on whichever channel. A write to address 12 or 13 sets it to 0.
- R4: A read at address 2n or 2n+1 returns the low byte of the working copy when the pointer is 0 and the high byte when it is 1. Reads at 9, 10, 11, 12, 14 and 15, and cycles without a read, return 0.
- R5: A pulse on `step_i[n]` adds 1 to channel n's working address, or subtracts 1 when mode bit 5 is set, and subtracts 1 from its working count. Both wrap modulo 2^16. A software write to the same register in the same cycle takes precedence, and the base copies do not change.
- R6: A write at address 8 stores `wdata` in the command byte that drives `cmd_o`.
- R7: A write at address 11 uses `wdata[1:0]` as the channel and stores `wdata[7:2]` as that channel's 6-bit mode. Bit 5 of the written byte, which is mode field bit 3, selects address decrement.
- R8: A read at address 8 returns the status byte. Bits 3:0 are terminal-count flags set by `tc_i` and held. Bits 7:4 are `req_i` OR the software requests. The read clears the flags, but a `tc_i` pulse in the same cycle keeps its flag set.
- R9: A write at address 9 uses `wdata[1:0]` as the channel. It sets that channel's software request when `wdata[2]` is 1 and clears it when `wdata[2]` is 0.
- R10: A write at address 13 clears the command byte, the terminal-count flags, the software requests, the temporary byte and the byte pointer. Addresses, counts and modes are kept.
- R11: `tmp_we_i` loads `tmp_data_i` into the temporary byte, and a read at address 13 returns it.
- R12: `load_o[n]` is high for exactly the one cycle after a software write to either of channel n's 16-bit registers.
- R13: An access with `cs` low changes nothing. When `rd` and `wr` are both high, the cycle is a write and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the read cycle |
| step_i | input | 4 | Per-channel working-register step from the sequencer |
| tc_i | input | 4 | Per-channel terminal-count pulse |
| req_i | input | 4 | Per-channel hardware request level |
| tmp_we_i | input | 1 | Temporary byte load enable |
| tmp_data_i | input | 8 | Temporary byte data |
| cmd_o | output | 8 | Command byte |
| mode_o | output | 24 | Mode fields, 6 bits per channel, channel 0 lowest |
| base_addr_o | output | 64 | Base addresses, 16 bits per channel |
| base_cnt_o | output | 64 | Base counts, 16 bits per channel |
| cur_addr_o | output | 64 | Working addresses, 16 bits per channel |
| cur_cnt_o | output | 64 | Working counts, 16 bits per channel |
| load_o | output | 4 | Per-channel reprogram pulse |
| sw_req_o | output | 4 | Software request bits |

## Verification
The bench builds the block with its default parameters: four channels and an 8-bit data port, so every 16-bit register takes exactly two accesses. With these values each channel slot in the fixed address map gets written, and a short step run can take a working address across 0xFFFF to 0x0000 and a zero count back to 0xFFFF. Directed accesses check that the one byte pointer is shared between channels and registers. A long stretch of random accesses then mixes pointer clears, master-clears, status reads and steps in every order.

// File: rtl/dma_regfile_pkg.sv
package dma_regfile_pkg;
  localparam logic [3:0] A_CMD_STAT = 4'h8;
  localparam logic [3:0] A_SWREQ    = 4'h9;
  localparam logic [3:0] A_MODE     = 4'hB;
  localparam logic [3:0] A_PTR_CLR  = 4'hC;
  localparam logic [3:0] A_MCLR_TMP = 4'hD;
  localparam int unsigned MODE_W    = 6;
  localparam int unsigned MODE_DEC  = 3;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_regfile_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_addr,
  input  logic               we_cnt,
  input  logic               hi,
  input  logic [DW-1:0]      wdata,
  input  logic               step,
  input  logic               mode_we,
  input  logic [MODE_W-1:0]  mode_d,
  output logic [2*DW-1:0]    base_addr,
  output logic [2*DW-1:0]    base_cnt,
  output logic [2*DW-1:0]    cur_addr,
  output logic [2*DW-1:0]    cur_cnt,
  output logic [MODE_W-1:0]  mode,
  output logic               load
);
  localparam int unsigned RW = 2 * DW;

  logic [RW-1:0] addr_merge, cnt_merge;

  always_comb begin
    addr_merge = hi ? {wdata, base_addr[DW-1:0]} : {base_addr[RW-1:DW], wdata};
    cnt_merge  = hi ? {wdata, base_cnt[DW-1:0]}  : {base_cnt[RW-1:DW], wdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      mode      <= '0;
      load      <= 1'b0;
    end else begin
      load <= we_addr | we_cnt;
      if (mode_we) mode <= mode_d;
      if (we_addr) begin
        base_addr <= addr_merge;
        cur_addr  <= addr_merge;
      end else if (step) begin
        cur_addr <= mode[MODE_DEC] ? cur_addr - 1'b1 : cur_addr + 1'b1;
      end
      if (we_cnt) begin
        base_cnt <= cnt_merge;
        cur_cnt  <= cnt_merge;
      end else if (step) begin
        cur_cnt <= cur_cnt - 1'b1;
      end
    end
  end

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_addr |=> $stable(base_addr)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !we_cnt) |=> cur_cnt == RW'($past(cur_cnt) - 1'b1)); // R5
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> $past(we_addr || we_cnt)); // R12
endmodule

// File: rtl/dma_stat.sv
module dma_stat #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mclr,
  input  logic            stat_rd,
  input  logic [NCH-1:0]  tc_i,
  input  logic [NCH-1:0]  req_i,
  input  logic            swreq_we,
  input  logic [1:0]      swreq_ch,
  input  logic            swreq_set,
  input  logic            tmp_we,
  input  logic [DW-1:0]   tmp_d,
  output logic [DW-1:0]   status,
  output logic [NCH-1:0]  sw_req,
  output logic [DW-1:0]   tmp
);
  logic [NCH-1:0] tc_flag;

  assign status = DW'({req_i | sw_req, tc_flag});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_flag <= '0;
      sw_req  <= '0;
      tmp     <= '0;
    end else if (mclr) begin
      tc_flag <= '0;
      sw_req  <= '0;
      tmp     <= '0;
    end else begin
      tc_flag <= (stat_rd ? '0 : tc_flag) | tc_i;
      if (swreq_we) sw_req[swreq_ch] <= swreq_set;
      if (tmp_we) tmp <= tmp_d;
    end
  end

  AST_MCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (tc_flag == '0 && sw_req == '0 && tmp == '0)); // R10
  AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd && !mclr) |=> ((tc_flag & $past(tc_flag)) == $past(tc_flag))); // R8
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_regfile_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs,
  input  logic                  rd,
  input  logic                  wr,
  input  logic [3:0]            addr,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  input  logic [NCH-1:0]        step_i,
  input  logic [NCH-1:0]        tc_i,
  input  logic [NCH-1:0]        req_i,
  input  logic                  tmp_we_i,
  input  logic [DW-1:0]         tmp_data_i,
  output logic [DW-1:0]         cmd_o,
  output logic [NCH*MODE_W-1:0] mode_o,
  output logic [NCH*2*DW-1:0]   base_addr_o,
  output logic [NCH*2*DW-1:0]   base_cnt_o,
  output logic [NCH*2*DW-1:0]   cur_addr_o,
  output logic [NCH*2*DW-1:0]   cur_cnt_o,
  output logic [NCH-1:0]        load_o,
  output logic [NCH-1:0]        sw_req_o
);
  localparam int unsigned RW  = 2 * DW;
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic          wr_acc, rd_acc, ch_hit, mclr, ff;
  logic [CHW-1:0] sel_ch;
  logic [RW-1:0] cur_a [NCH];
  logic [RW-1:0] cur_c [NCH];
  logic [DW-1:0] status, tmp;
  logic [RW-1:0] sel_word;

  assign wr_acc = cs & wr;
  assign rd_acc = cs & rd & ~wr;
  assign ch_hit = ~addr[3];
  assign sel_ch = addr[CHW:1];
  assign mclr   = wr_acc && addr == A_MCLR_TMP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= 1'b0;
    else if (wr_acc && (addr == A_PTR_CLR || addr == A_MCLR_TMP)) ff <= 1'b0;
    else if ((wr_acc || rd_acc) && ch_hit) ff <= ~ff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_o <= '0;
    else if (mclr) cmd_o <= '0;
    else if (wr_acc && addr == A_CMD_STAT) cmd_o <= wdata;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit_g;
    assign hit_g = wr_acc && ch_hit && sel_ch == CHW'(g);
    dma_chan #(.DW(DW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_addr   (hit_g && !addr[0]),
      .we_cnt    (hit_g && addr[0]),
      .hi        (ff),
      .wdata     (wdata),
      .step      (step_i[g]),
      .mode_we   (wr_acc && addr == A_MODE && wdata[1:0] == 2'(g)),
      .mode_d    (wdata[7:2]),
      .base_addr (base_addr_o[g*RW +: RW]),
      .base_cnt  (base_cnt_o[g*RW +: RW]),
      .cur_addr  (cur_a[g]),
      .cur_cnt   (cur_c[g]),
      .mode      (mode_o[g*MODE_W +: MODE_W]),
      .load      (load_o[g])
    );
    assign cur_addr_o[g*RW +: RW] = cur_a[g];
    assign cur_cnt_o[g*RW +: RW]  = cur_c[g];
  end

  dma_stat #(.NCH(NCH), .DW(DW)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .mclr      (mclr),
    .stat_rd   (rd_acc && addr == A_CMD_STAT),
    .tc_i      (tc_i),
    .req_i     (req_i),
    .swreq_we  (wr_acc && addr == A_SWREQ),
    .swreq_ch  (wdata[1:0]),
    .swreq_set (wdata[2]),
    .tmp_we    (tmp_we_i),
    .tmp_d     (tmp_data_i),
    .status    (status),
    .sw_req    (sw_req_o),
    .tmp       (tmp)
  );

  always_comb begin
    sel_word = addr[0] ? cur_c[sel_ch] : cur_a[sel_ch];
    rdata = '0;
    if (rd_acc) begin
      if (ch_hit) rdata = ff ? sel_word[RW-1:DW] : sel_word[DW-1:0];
      else if (addr == A_CMD_STAT) rdata = status;
      else if (addr == A_MCLR_TMP) rdata = tmp;
    end
  end

  AST_FF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && (rd || wr) && !addr[3]) |=> ff != $past(ff)); // R3
  AST_FF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && (addr == A_PTR_CLR || addr == A_MCLR_TMP)) |=> !ff); // R3
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_acc && (addr == A_CMD_STAT || addr == A_MCLR_TMP)) |=> $stable(cmd_o)); // R13
endmodule

// File: tb/sim_dma_regfile.sv
module sim_dma_regfile;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, rd = 0, wr = 0, tw = 0;
  logic [3:0] addr = 0, st = 0, tc = 0, rq = 0;
  logic [7:0] wd = 0, td = 0, rdata, cmd_o;
  logic [23:0] mode_o;
  logic [63:0] ba, bc, ca, cc;
  logic [3:0] load_o, swr_o;
  int compared = 0, mismatched = 0;

  always #5 clk = ~clk;

  dma_regfile u0 (.clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wd), .rdata(rdata), .step_i(st), .tc_i(tc), .req_i(rq), .tmp_we_i(tw),
    .tmp_data_i(td), .cmd_o(cmd_o), .mode_o(mode_o), .base_addr_o(ba), .base_cnt_o(bc),
    .cur_addr_o(ca), .cur_cnt_o(cc), .load_o(load_o), .sw_req_o(swr_o));

  // behavioural reference state
  int m_ba[4], m_bc[4], m_ca[4], m_cc[4], m_mode[4];
  int m_ff = 0, m_cmd = 0, m_tcf = 0, m_swr = 0, m_tmp = 0, m_load = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rdata();
    int v;
    if (!(cs && rd && !wr)) return 0;
    if (addr < 8) begin
      v = addr[0] ? m_cc[addr >> 1] : m_ca[addr >> 1];
      return m_ff ? (v >> 8) & 255 : v & 255;
    end
    if (addr == 8) return (((rq | m_swr) & 15) << 4) | m_tcf;
    if (addr == 13) return m_tmp;
    return 0;
  endfunction

  task automatic model_step();
    bit wa, ra;
    int ch, v, old_mode[4];
    wa = cs && wr; ra = cs && rd && !wr;
    m_load = 0;
    old_mode = m_mode;
    for (int c = 0; c < 4; c++) begin
      if (wa && addr < 8 && (addr >> 1) == c && !addr[0]) begin
        v = m_ff ? (m_ba[c] & 255) | (wd << 8) : (m_ba[c] & 'hFF00) | wd;
        m_ba[c] = v; m_ca[c] = v; m_load |= 1 << c;
      end else if (st[c]) m_ca[c] = ((old_mode[c] >> 3) & 1) ? (m_ca[c] - 1) & 'hFFFF : (m_ca[c] + 1) & 'hFFFF;
      if (wa && addr < 8 && (addr >> 1) == c && addr[0]) begin
        v = m_ff ? (m_bc[c] & 255) | (wd << 8) : (m_bc[c] & 'hFF00) | wd;
        m_bc[c] = v; m_cc[c] = v; m_load |= 1 << c;
      end else if (st[c]) m_cc[c] = (m_cc[c] - 1) & 'hFFFF;
    end
    if (wa && addr == 11) begin ch = wd & 3; m_mode[ch] = wd >> 2; end
    if (wa && addr == 13) begin
      m_cmd = 0; m_tcf = 0; m_swr = 0; m_tmp = 0;
    end else begin
      if (wa && addr == 8) m_cmd = wd;
      m_tcf = ((ra && addr == 8) ? 0 : m_tcf) | tc;
      if (wa && addr == 9) begin
        ch = wd & 3;
        if (wd[2]) m_swr |= 1 << ch; else m_swr &= ~(1 << ch);
      end
      if (tw) m_tmp = td;
    end
    if (wa && (addr == 12 || addr == 13)) m_ff = 0;
    else if ((wa || ra) && addr < 8) m_ff ^= 1;
  endtask

  task automatic cmp_outputs();
    logic [63:0] eba, ebc, eca, ecc; logic [23:0] emo;
    for (int c = 0; c < 4; c++) begin
      eba[c*16 +: 16] = 16'(m_ba[c]); ebc[c*16 +: 16] = 16'(m_bc[c]);
      eca[c*16 +: 16] = 16'(m_ca[c]); ecc[c*16 +: 16] = 16'(m_cc[c]);
      emo[c*6 +: 6] = 6'(m_mode[c]);
    end
    chk("R2 base_addr", ba, eba);
    chk("R2 base_cnt", bc, ebc);
    chk("R5 cur_addr", ca, eca);
    chk("R5 cur_cnt", cc, ecc);
    chk("R6 cmd", 64'(cmd_o), 64'(m_cmd));
    chk("R7 mode", 64'(mode_o), 64'(emo));
    chk("R9 sw_req", 64'(swr_o), 64'(m_swr));
    chk("R12 load", 64'(load_o), 64'(m_load));
  endtask

  // one bus cycle: drive after falling edge, check read data mid-low phase,
  // advance the model at the rising edge, check registered outputs after it
  task automatic cyc(logic c_, logic r_, logic w_, logic [3:0] a_, logic [7:0] d_,
                     logic [3:0] s_ = 0, logic [3:0] t_ = 0, logic [3:0] q_ = 0,
                     logic tw_ = 0, logic [7:0] td_ = 0);
    @(negedge clk);
    cs = c_; rd = r_; wr = w_; addr = a_; wd = d_; st = s_; tc = t_; rq = q_; tw = tw_; td = td_;
    #1 chk("R4/R8/R11 rdata", 64'(rdata), 64'(exp_rdata()));
    @(posedge clk);
    model_step();
    #1 cmp_outputs();
  endtask

  task automatic wr_reg(logic [3:0] a, logic [7:0] d); cyc(1, 0, 1, a, d); endtask
  task automatic rd_reg(logic [3:0] a); cyc(1, 1, 0, a, 0); endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin m_ba[c]=0; m_bc[c]=0; m_ca[c]=0; m_cc[c]=0; m_mode[c]=0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    cyc(0, 0, 0, 0, 0);
    chk("R1 rdata idle", 64'(rdata), 0);
    // R2: low then high byte, address and count of channel 0
    wr_reg(0, 8'h34); wr_reg(0, 8'h12); wr_reg(1, 8'hFF); wr_reg(1, 8'h00);
    // R4: read back working copy low then high
    rd_reg(0); rd_reg(0); rd_reg(1); rd_reg(1);
    // R3: pointer shared across channels, cleared by address 12
    wr_reg(2, 8'hAA); wr_reg(4, 8'hBB); wr_reg(12, 0); wr_reg(2, 8'hCC); wr_reg(2, 8'h0D);
    // R7: channel 1 decrement, channel 0 single increment
    wr_reg(11, 8'h21); wr_reg(11, 8'h44);
    // R5: steps, wrap on channel 2 address 0xFFFF and zero count
    wr_reg(4, 8'hFF); wr_reg(4, 8'hFF);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 4'b0111);
    wr_reg(12, 0);
    cyc(1, 0, 1, 0, 8'h77, 4'b0001);          // R5: write beats step on address
    // R6: command byte
    wr_reg(8, 8'hA5);
    // R9, R8: software request, status read clears flags, same-cycle tc keeps flag
    wr_reg(9, 8'h07); cyc(0, 0, 0, 0, 0, 0, 4'b0100);
    cyc(1, 1, 0, 8, 0, 0, 4'b0001, 4'b0011);
    rd_reg(8); wr_reg(9, 8'h03); rd_reg(8);
    // R11: temporary byte
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h5A); rd_reg(13);
    // R13: deselected write, read with write
    cyc(0, 0, 1, 8, 8'h11); cyc(1, 1, 1, 8, 8'h3C); cyc(0, 1, 0, 0, 0);
    // R10: master clear keeps channel state
    wr_reg(9, 8'h05); cyc(0, 0, 0, 0, 0, 0, 4'b1000); wr_reg(0, 8'h01);
    wr_reg(13, 0); rd_reg(8); rd_reg(0); rd_reg(0); rd_reg(13);
    // mixed random traffic covering all requirements together
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a; logic [2:0] k;
      a = 4'($urandom); k = 3'($urandom);
      cyc(k != 0, k[0], k[1], a, 8'($urandom), 4'($urandom) & 4'($urandom),
          4'($urandom) & 4'($urandom), 4'($urandom), k == 3'd7, 8'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule